// File: doc/BRIEF.md
# MDIO Management Master

This block is a memory-mapped master for the two-wire PHY management bus. It produces the management clock (MDC) and drives the bidirectional data line through separate output, output-enable and input pins. Software sets up a few small registers and writes a command word with its go bit set. The block then serialises one complete management frame and clears the go bit when the frame has finished. Software polls the go bit until it reads 0.

One command register covers both frame clauses. For clause 22, a single command performs a read or a write. For clause 45, software first issues an address command, which sends the contents of a dedicated address register. Once that command has completed, software issues a write or read command to the same port and device. During read frames the block releases the line for the turnaround. It checks that the PHY pulled the second turnaround bit low, and it shifts the 16 returned bits into the read data register.

Top module: `mdio_master`

## Requirements
- R1: After the active-low reset, every register reads 0: command at byte offset 0x00, address at 0x04, write data at 0x08, read data at 0x0C and status at 0x10. MDC is low and the data line is released, so the output enable is 0.
- R2: The command register reads back with the register/device number in bits 4:0, the port in bits 9:5, the opcode in bits 11:10, the clause select in bits 13:12 and the go bit in bit 14. Writing bit 14 as 1 starts a frame. Bit 14 reads 1 until the last bit has been clocked and then returns to 0. The output enable is only high while a frame is in progress.
- R3: Every frame opens with PRE_LEN bits at 1. Next comes the start code, which is 01 when the clause select is 1 (clause 22) and 00 for any other select value (clause 45). After the start code the frame carries the two opcode bits, then the 5 port bits, then the 5 device/register bits, each field MSB first.
- R4: A frame that is not a read drives turnaround 1 then 0, followed by 16 data bits, MSB first. A clause-45 frame with opcode 0 sends the address register. Every other non-read frame sends the write data register.
- R5: Read frames are clause 22 with opcode 2, or clause 45 with opcode 2 or 3. In a read frame the master releases the line from the first turnaround bit to the end of the frame. It captures the 16 bits after the turnaround, MSB first, into read data bits 15:0.
- R6: If the line is high at the second turnaround bit of a read frame, status bit 0 becomes 1. When it is low, status stays 0. Starting any command clears status bit 0.
- R7: MDC stays low when no frame is in progress. During a frame, MDC runs with a period of 2*CLK_DIV system clocks. The data output changes only together with a falling MDC edge, and the PHY's line is sampled at the rising edge.
- R8: While the go bit reads 1, writes to the command, address and write data registers have no effect. No second frame starts from such a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line value driven by the master |
| mdioOe | output | 1 | Data line output enable (1 = master drives) |
| mdioIn | input | 1 | Resolved data line value |

## Verification
The hardest cases to reach from the ports are a command that lands in the middle of a frame and a PHY that stays silent at turnaround. The bench starts a write frame and, while the go bit still reads 1, overwrites all three writable registers with different values and writes a second go. It then checks that the wire payload, the register readback and the idle bus afterwards all reflect only the first command. The bench's PHY responder takes a configurable value for the second turnaround bit. This lets a failed read be produced on purpose, and a following good read shows that the status is cleared. A sweep over every select/opcode pair with several address and data patterns covers the frame layout of both clauses.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_AW = 5;
  localparam logic [REG_AW-1:0] OFF_CMD    = 5'h00;
  localparam logic [REG_AW-1:0] OFF_ADDR   = 5'h04;
  localparam logic [REG_AW-1:0] OFF_WDATA  = 5'h08;
  localparam logic [REG_AW-1:0] OFF_RDATA  = 5'h0C;
  localparam logic [REG_AW-1:0] OFF_STATUS = 5'h10;
  localparam int CMD_GO = 14;
  localparam logic [1:0] SEL_C22 = 2'd1;

  typedef struct packed {
    logic load;     // latch a new frame into the shifter
    logic shift;    // advance to the next wire bit
    logic sample;   // capture one read data bit
    logic taCheck;  // check the second turnaround bit
  } strobeT;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 10,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [15:0]       regWdata,
  output logic              busy,
  output logic              mdc,
  output logic              mdioOe,
  output logic              isC22,
  output logic              isRead,
  output logic [1:0]        cmdSel,
  output logic [1:0]        cmdOp,
  output logic [4:0]        cmdPrt,
  output logic [4:0]        cmdDev,
  output logic [15:0]       addrReg,
  output logic [15:0]       wdataReg,
  output strobeT            stb
);
  localparam int FRAME_BITS = PRE_LEN + 32;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int DIV_W      = $clog2(CLK_DIV + 1);
  localparam int TA_POS     = PRE_LEN + 14;
  localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] TA_FIRST   = BIT_W'(TA_POS);
  localparam logic [BIT_W-1:0] TA_SECOND  = BIT_W'(TA_POS + 1);
  localparam logic [BIT_W-1:0] DATA_FIRST = BIT_W'(TA_POS + 2);
  localparam logic [DIV_W-1:0] DIV_END    = DIV_W'(CLK_DIV - 1);

  logic             primed;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             divEnd, riseTick, fallTick, lastBit;

  assign isC22    = (cmdSel == SEL_C22);
  assign isRead   = isC22 ? (cmdOp == 2'd2) : cmdOp[1];
  assign divEnd   = primed && (divCnt == DIV_END);
  assign riseTick = divEnd && !mdc;
  assign fallTick = divEnd && mdc;
  assign lastBit  = (bitCnt == LAST_BIT);
  assign mdioOe   = primed && !(isRead && bitCnt >= TA_FIRST);

  always_comb begin
    stb.load    = busy && !primed;
    stb.shift   = fallTick && !lastBit;
    stb.sample  = riseTick && isRead && (bitCnt >= DATA_FIRST);
    stb.taCheck = riseTick && isRead && (bitCnt == TA_SECOND);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      primed   <= 1'b0;
      mdc      <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
      cmdSel   <= '0;
      cmdOp    <= '0;
      cmdPrt   <= '0;
      cmdDev   <= '0;
      addrReg  <= '0;
      wdataReg <= '0;
    end else begin
      if (regWe && !busy) begin
        case (regAddr)
          OFF_CMD: begin
            {cmdSel, cmdOp, cmdPrt, cmdDev} <= regWdata[13:0];
            busy   <= regWdata[CMD_GO];
            bitCnt <= '0;
          end
          OFF_ADDR:  addrReg  <= regWdata;
          OFF_WDATA: wdataReg <= regWdata;
          default: ;
        endcase
      end
      if (stb.load) begin
        primed <= 1'b1;
        divCnt <= '0;
        mdc    <= 1'b0;
      end else if (primed) begin
        if (divEnd) begin
          divCnt <= '0;
          mdc    <= ~mdc;
          if (fallTick) begin
            if (lastBit) begin
              busy   <= 1'b0;
              primed <= 1'b0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_dpath.sv
module mdio_dpath
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobeT      stb,
  input  logic        isC22,
  input  logic [1:0]  cmdOp,
  input  logic [4:0]  cmdPrt,
  input  logic [4:0]  cmdDev,
  input  logic [15:0] addrReg,
  input  logic [15:0] wdataReg,
  input  logic        mdioIn,
  output logic        mdioOut,
  output logic [15:0] rdData,
  output logic        rdFail
);
  localparam int FRAME_BITS = PRE_LEN + 32;

  logic [FRAME_BITS-1:0] shreg;
  logic [15:0]           payload;
  logic [1:0]            startCode;

  assign payload   = (!isC22 && cmdOp == 2'd0) ? addrReg : wdataReg;
  assign startCode = isC22 ? 2'b01 : 2'b00;
  assign mdioOut   = shreg[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg  <= '1;
      rdData <= '0;
      rdFail <= 1'b0;
    end else begin
      if (stb.load) begin
        shreg  <= {{PRE_LEN{1'b1}}, startCode, cmdOp, cmdPrt, cmdDev, 2'b10, payload};
        rdFail <= 1'b0;
      end else if (stb.shift) begin
        shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
      end
      if (stb.sample)
        rdData <= {rdData[14:0], mdioIn};
      if (stb.taCheck && mdioIn)
        rdFail <= 1'b1;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 10,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  strobeT      stb;
  logic        busy, isC22, isRead, rdFail;
  logic [1:0]  cmdSel, cmdOp;
  logic [4:0]  cmdPrt, cmdDev;
  logic [15:0] addrReg, wdataReg, rdData;
  logic [13:0] cmdFields;
  logic        unusedHigh;

  assign unusedHigh = ^regWdata[31:16];
  assign cmdFields  = {cmdSel, cmdOp, cmdPrt, cmdDev};

  mdio_ctrl #(.CLK_DIV(CLK_DIV), .PRE_LEN(PRE_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata[15:0]), .busy(busy), .mdc(mdc), .mdioOe(mdioOe),
    .isC22(isC22), .isRead(isRead), .cmdSel(cmdSel), .cmdOp(cmdOp),
    .cmdPrt(cmdPrt), .cmdDev(cmdDev), .addrReg(addrReg),
    .wdataReg(wdataReg), .stb(stb)
  );

  mdio_dpath #(.PRE_LEN(PRE_LEN)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .isC22(isC22), .cmdOp(cmdOp),
    .cmdPrt(cmdPrt), .cmdDev(cmdDev), .addrReg(addrReg),
    .wdataReg(wdataReg), .mdioIn(mdioIn), .mdioOut(mdioOut),
    .rdData(rdData), .rdFail(rdFail)
  );

  always_comb begin
    case (regAddr)
      OFF_CMD:    regRdata = {17'd0, busy, cmdFields};
      OFF_ADDR:   regRdata = {16'd0, addrReg};
      OFF_WDATA:  regRdata = {16'd0, wdataReg};
      OFF_RDATA:  regRdata = {16'd0, rdData};
      OFF_STATUS: regRdata = {31'd0, rdFail};
      default:    regRdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        mdc,
  input logic        mdioOe,
  input logic        mdioOut,
  input logic        rdFail,
  input logic        isRead,
  input logic [13:0] cmdFields
);
  AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> busy); // R2

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc); // R7

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (mdioOe && $past(mdioOe) && !$fell(mdc)) |-> $stable(mdioOut)); // R7

  AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(cmdFields)); // R8

  AST_RELEASE_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(mdioOe) && busy) |-> isRead); // R5

  AST_FAIL_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> !rdFail); // R6
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .mdc(mdc), .mdioOe(mdioOe),
  .mdioOut(mdioOut), .rdFail(rdFail), .isRead(isRead), .cmdFields(cmdFields)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BENCH_DIV  = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  int nChecks = 0;
  int nFail = 0;

  int          phyBit = 0;
  logic        phyDrive = 1'b1;
  logic        taVal = 1'b0;
  logic [15:0] respData = '0;
  logic [63:0] capFrame, capOe;
  time         tRise0, tRise1;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.CLK_DIV(BENCH_DIV), .PRE_LEN(32)) u_mdio_master (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  assign mdioIn = mdioOe ? mdioOut : phyDrive;

  // PHY responder: records every sampled bit, drives on falling MDC
  always @(posedge mdc) begin
    if (phyBit < 64) begin
      capFrame[63-phyBit] = mdioIn;
      capOe[63-phyBit]    = mdioOe;
    end
    if (phyBit == 0) tRise0 = $time;
    if (phyBit == 1) tRise1 = $time;
    phyBit = phyBit + 1;
  end

  always @(negedge mdc) begin
    if (phyBit == 47)                    phyDrive = taVal;
    else if (phyBit >= 48 && phyBit < 64) phyDrive = respData[63-phyBit];
    else                                 phyDrive = 1'b1;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic startCmd(input logic [1:0] s, input logic [1:0] o,
                          input logic [4:0] p, input logic [4:0] dv);
    phyBit = 0;
    capFrame = '0;
    capOe = '0;
    wr(5'h00, {17'd0, 1'b1, s, o, p, dv});
  endtask

  task automatic waitDone;
    logic [31:0] v;
    int n;
    n = 0;
    v = 32'h4000;
    while (v[14] && n < 2000) begin
      rd(5'h00, v);
      n++;
    end
    if (v[14]) chk("R2 go bit never cleared", 64'(v[14]), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL R2 watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [4:0]  prt, dev;
    logic [15:0] wd, ad, rsp, expData;
    logic [63:0] expFrame, expOe;
    logic        c22, rdF;
    int          idx;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 mdc idle", 64'(mdc), 64'd0);
    chk("R1 oe idle", 64'(mdioOe), 64'd0);
    rstN = 1'b1;
    rd(5'h00, v); chk("R1 cmd reset", 64'(v), 64'd0);
    rd(5'h04, v); chk("R1 addr reset", 64'(v), 64'd0);
    rd(5'h08, v); chk("R1 wdata reset", 64'(v), 64'd0);
    rd(5'h0C, v); chk("R1 rdata reset", 64'(v), 64'd0);
    rd(5'h10, v); chk("R1 status reset", 64'(v), 64'd0);

    // Sweep: every select/opcode pair, three address/data patterns
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 4; o++) begin
        for (int k = 0; k < 3; k++) begin
          idx = s * 12 + o * 3 + k;
          prt = 5'(idx * 7 + 3);
          dev = 5'(idx * 13 + k);
          wd  = 16'(idx * 40503 + 4660);
          ad  = 16'(~(idx * 9001));
          rsp = 16'(idx * 26021 + 777);
          wr(5'h04, {16'd0, ad});
          wr(5'h08, {16'd0, wd});
          respData = rsp;
          taVal = 1'b0;
          startCmd(2'(s), 2'(o), prt, dev);
          waitDone();
          c22 = (s == 1);
          rdF = c22 ? (o == 2) : (o >= 2);
          expData  = rdF ? rsp : ((!c22 && o == 0) ? ad : wd);
          expFrame = {32'hFFFF_FFFF, (c22 ? 2'b01 : 2'b00), 2'(o), prt, dev, 2'b10, expData};
          expOe    = rdF ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
          chk("R3 header", 64'(capFrame[63:18]), 64'(expFrame[63:18]));
          chk(rdF ? "R5 turnaround/data" : "R4 turnaround/data",
              64'(capFrame[17:0]), 64'(expFrame[17:0]));
          chk("R5 output enable", capOe, expOe);
          rd(5'h00, v);
          chk("R2 cmd readback", 64'(v), 64'({17'd0, 1'b0, 2'(s), 2'(o), prt, dev}));
          if (rdF) begin
            rd(5'h0C, v); chk("R5 read data", 64'(v), 64'(rsp));
            rd(5'h10, v); chk("R6 status ok", 64'(v), 64'd0);
          end
          if (idx == 0)
            chk("R7 mdc period", 64'(tRise1 - tRise0), 64'(2 * BENCH_DIV * CLK_PERIOD));
          chk("R7 mdc low idle", 64'(mdc), 64'd0);
        end
      end
    end

    // R6: silent PHY at turnaround, then a good read clears status
    respData = 16'h5A5A;
    taVal = 1'b1;
    startCmd(2'd1, 2'd2, 5'd9, 5'd4);
    waitDone();
    rd(5'h10, v); chk("R6 status fail", 64'(v), 64'd1);
    taVal = 1'b0;
    startCmd(2'd0, 2'd3, 5'd9, 5'd4);
    waitDone();
    rd(5'h10, v); chk("R6 status cleared", 64'(v), 64'd0);
    rd(5'h0C, v); chk("R5 read after fail", 64'(v), 64'h5A5A);

    // R8: writes during a frame are ignored
    wr(5'h04, 32'h0000_1111);
    wr(5'h08, 32'h0000_2222);
    startCmd(2'd1, 2'd1, 5'd5, 5'd6);
    repeat (10) @(negedge clk);
    rd(5'h00, v); chk("R2 go bit set mid-frame", 64'(v[14]), 64'd1);
    wr(5'h04, 32'h0000_DEAD);
    wr(5'h08, 32'h0000_BEEF);
    wr(5'h00, {17'd0, 1'b1, 2'd0, 2'd2, 5'd17, 5'd30});
    waitDone();
    chk("R8 payload unchanged", 64'(capFrame[15:0]), 64'h2222);
    rd(5'h04, v); chk("R8 addr kept", 64'(v), 64'h1111);
    rd(5'h08, v); chk("R8 wdata kept", 64'(v), 64'h2222);
    rd(5'h00, v); chk("R8 cmd kept", 64'(v), 64'({17'd0, 1'b0, 2'd1, 2'd1, 5'd5, 5'd6}));
    repeat (20) @(negedge clk);
    rd(5'h00, v); chk("R8 no second frame", 64'(v[14]), 64'd0);
    chk("R8 bus idle", 64'({mdc, mdioOe}), 64'd0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule